// File: doc/BRIEF.md
# Serial GPIO Chain Master

This block lets software reach a large number of slow general-purpose pins through four wires. It drives two daisy-chained strings of external shift registers: a parallel-load, serial-out string that gathers input pins, and a serial-in, parallel-latch string that drives output pins. Every pin has one input bit and one output bit. Software programs an enable bit, a pin count in groups of eight, and a shift clock divider through APB registers.

While enabled, the block runs scan frames back to back. Each frame shifts every configured output bit out and, on the same clock edges, shifts every input bit in. After the last bit it raises a latch strobe for the output string and a load strobe for the input string together. Output values are written per 32-pin bank and can be read back from a separate address, so single bits can be changed by read-modify-write. Input values become visible to software only once a frame has completed.

Top module: `sgpio_chain_master`

## Requirements
- R1: After reset the control, readback and input value registers read 0, and the shift clock, serial data out, latch strobe and load strobe outputs are all low.
- R2: The control register is at offset 0x000. Bit 0 is the enable, bits 9:6 hold the pin count divided by 8, and bits 31:16 hold the divider value D. It reads back the stored fields, and every other bit reads 0.
- R3: While frames run, each high phase and each low phase of the shift clock lasts D+1 APB clock cycles.
- R4: A frame with a pin-count field of G carries N = 8*G bits. Output pin k is placed on serial data out before the k-th rising shift clock edge, pin 0 first, and stays stable while the shift clock is high. Each frame has exactly N rising edges.
- R5: Serial data in is sampled on every rising shift clock edge, and the k-th sample of a frame becomes input pin k.
- R6: The latch strobe and the load strobe rise together on the same cycle as the last falling shift clock edge of a frame. Both stay high for D+1 cycles while the shift clock is low, and then the next frame begins.
- R7: The input value registers change only when a frame ends. A read in the middle of a frame returns the previous complete frame.
- R8: The output readback register of bank b, at offset 0x200+4b, returns the value last written to the output data register at offset 0x100+4b. The output data offset itself reads as 0.
- R9: Pin p is bit p mod 32 of bank p/32. Bits for pins at or above 80 read 0 and cannot be set. Accesses to a bank index that does not exist read 0 and change nothing. The input values of bank b are at offset 0x300+4b, and input pins at or above N read 0.
- R10: While the enable bit is 0, the shift clock and both strobes are held low from the next cycle on. Clearing the enable in the middle of a frame abandons that frame.
- R11: A pin-count field of 0, or a field above 10, produces no shift clock activity, even with the enable bit set.
- R12: The output bits of a frame are captured when the frame starts. A write made during a frame appears first in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock, also the source of the shift clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high, read when low |
| paddr | input | 10 | APB byte address; bits 1:0 must be 0 |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| sclk_o | output | 1 | Shift clock to both external chains |
| sdout_o | output | 1 | Serial data to the output chain |
| sdin_i | input | 1 | Serial data from the input chain |
| latch_o | output | 1 | End-of-frame latch strobe for the output chain |
| load_o | output | 1 | End-of-frame parallel-load strobe for the input chain |

## Verification
The hardest case to reach is a write, or a change on the serial input, that lands in the middle of a frame. The block has to keep shifting the snapshot taken at frame start, and it must not expose a half-shifted input word. The bench models both external chains. It synchronises to the rising edge of the latch strobe, waits a few shift clock edges into the next frame, and only then writes new output data or changes the input pattern. It then checks the latched frames and the input reads on each side of the following frame boundaries. Clearing the enable at the same mid-frame point tests the abort path.

// File: rtl/sgpio_chain_master.sv
module sgpio_chain_master #(
  parameter int MAX_PINS = 80,
  parameter int DIV_W    = 16
) (
  input  logic        pclk,
  input  logic        presetn,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [9:0]  paddr,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata,
  output logic        sclk_o,
  output logic        sdout_o,
  input  logic        sdin_i,
  output logic        latch_o,
  output logic        load_o
);
  localparam int NBANK = (MAX_PINS + 31) / 32;
  localparam int NGRP  = MAX_PINS / 8;
  localparam int CNT_W = $clog2(NGRP + 1);
  localparam int IDX_W = $clog2(MAX_PINS);
  localparam int FLAT  = NBANK * 32;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_STROBE} st_t;

  logic                ctrl_en;
  logic [CNT_W-1:0]    ctrl_grp;
  logic [DIV_W-1:0]    ctrl_div;
  logic [31:0]         out_q [NBANK];
  logic [MAX_PINS-1:0] out_flat;
  logic [MAX_PINS-1:0] tx_q;
  logic [FLAT-1:0]     hold_q;
  logic [FLAT-1:0]     in_q;
  logic [DIV_W-1:0]    pre_q;
  logic [IDX_W-1:0]    bit_q;
  logic [IDX_W-1:0]    last_q;
  st_t                 st_q;
  logic                sclk_q;
  logic                strb_q;

  wire             acc    = psel & penable & (paddr[1:0] == 2'b00);
  wire             wr     = acc & pwrite;
  wire [1:0]       area   = paddr[9:8];
  wire [5:0]       bank   = paddr[7:2];
  wire             grp_ok = (ctrl_grp != '0) && (ctrl_grp <= CNT_W'(NGRP));
  wire             run    = ctrl_en & grp_ok;
  wire             tick   = (pre_q >= ctrl_div);
  wire [IDX_W-1:0] last_d = IDX_W'({ctrl_grp, 3'b000} - (CNT_W + 3)'(1));

  function automatic logic [31:0] bank_mask(input int b);
    int n;
    n = MAX_PINS - 32 * b;
    if (n >= 32) return '1;
    return (32'd1 << n) - 32'd1;
  endfunction

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      ctrl_en  <= 1'b0;
      ctrl_grp <= '0;
      ctrl_div <= '0;
      for (int b = 0; b < NBANK; b++) out_q[b] <= '0;
    end else if (wr) begin
      if (area == 2'd0 && bank == 6'd0) begin
        ctrl_en  <= pwdata[0];
        ctrl_grp <= pwdata[6 +: CNT_W];
        ctrl_div <= pwdata[16 +: DIV_W];
      end
      if (area == 2'd1)
        for (int b = 0; b < NBANK; b++)
          if (bank == 6'(b)) out_q[b] <= pwdata & bank_mask(b);
    end
  end

  always_comb
    for (int i = 0; i < MAX_PINS; i++) out_flat[i] = out_q[i / 32][i % 32];

  always_comb begin
    prdata = '0;
    case (area)
      2'd0: if (bank == 6'd0) begin
        prdata[0]           = ctrl_en;
        prdata[6 +: CNT_W]  = ctrl_grp;
        prdata[16 +: DIV_W] = ctrl_div;
      end
      2'd2: for (int b = 0; b < NBANK; b++) if (bank == 6'(b)) prdata = out_q[b];
      2'd3: for (int b = 0; b < NBANK; b++) if (bank == 6'(b)) prdata = in_q[b*32 +: 32];
      default: ;
    endcase
  end

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      st_q   <= S_IDLE;
      sclk_q <= 1'b0;
      strb_q <= 1'b0;
      pre_q  <= '0;
      bit_q  <= '0;
      last_q <= '0;
      tx_q   <= '0;
      hold_q <= '0;
      in_q   <= '0;
    end else if (!run) begin
      st_q   <= S_IDLE;
      sclk_q <= 1'b0;
      strb_q <= 1'b0;
      pre_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          st_q   <= S_SHIFT;
          tx_q   <= out_flat;
          hold_q <= '0;
          last_q <= last_d;
          bit_q  <= '0;
          pre_q  <= '0;
        end
        S_SHIFT: begin
          if (!tick) begin
            pre_q <= pre_q + DIV_W'(1);
          end else begin
            pre_q <= '0;
            if (!sclk_q) begin
              sclk_q        <= 1'b1;
              hold_q[bit_q] <= sdin_i;
            end else begin
              sclk_q <= 1'b0;
              if (bit_q == last_q) begin
                st_q   <= S_STROBE;
                strb_q <= 1'b1;
                in_q   <= hold_q;
              end else begin
                bit_q <= bit_q + IDX_W'(1);
                tx_q  <= tx_q >> 1;
              end
            end
          end
        end
        S_STROBE: begin
          if (!tick) begin
            pre_q <= pre_q + DIV_W'(1);
          end else begin
            st_q   <= S_SHIFT;
            strb_q <= 1'b0;
            pre_q  <= '0;
            tx_q   <= out_flat;
            hold_q <= '0;
            last_q <= last_d;
            bit_q  <= '0;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign sclk_o  = sclk_q;
  assign sdout_o = tx_q[0];
  assign latch_o = strb_q;
  assign load_o  = strb_q;
endmodule

// File: rtl/sgpio_chain_master_chk.sv
module sgpio_chain_master_chk #(
  parameter int W = 96
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         sclk,
  input logic         sdout,
  input logic         latch,
  input logic         load,
  input logic [W-1:0] inv
);
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(sdout));

  assert_strobe_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch || load) |-> !sclk);

  assert_strobe_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch) |-> $fell(sclk));

  assert_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(inv) |-> $rose(latch));

  // also covers R11: an invalid pin count drops run
  assert_stop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sclk && !latch && !load));
endmodule

bind sgpio_chain_master sgpio_chain_master_chk #(.W(FLAT)) u_chk (
  .clk   (pclk),
  .rst_n (presetn),
  .run   (run),
  .sclk  (sclk_o),
  .sdout (sdout_o),
  .latch (latch_o),
  .load  (load_o),
  .inv   (in_q)
);

// File: tb/sgpio_chain_master_tb.sv
module sgpio_chain_master_tb;
  localparam int NP = 80;
  localparam int NB = 3;

  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [9:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  wire  [31:0] prdata;
  wire         sclk_o, sdout_o, latch_o, load_o;
  logic        sdin_i = 1'b0;

  always #2 pclk = ~pclk;

  sgpio_chain_master u_dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .sclk_o(sclk_o), .sdout_o(sdout_o), .sdin_i(sdin_i),
    .latch_o(latch_o), .load_o(load_o)
  );

  int checks = 0, errors = 0;
  int ocnt = 0, icnt = 0, rise_cnt = 0, cur_n = 80;
  logic [NP-1:0] in_pat = '0, cap = '0, exp_out = '0, mon_e;
  logic [NP-1:0] exp_q [$];
  logic [31:0] rd;
  bit done = 0;
  event chain_rst_ev;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NP-1:0] nmask(input int n);
    logic [NP-1:0] m = '0;
    for (int i = 0; i < NP; i++) if (i < n) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic [31:0] in_bank(input logic [NP-1:0] p, input int b, input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < 32; i++) if (b*32 + i < n) v[i] = p[b*32 + i];
    return v;
  endfunction

  task automatic apb_write(input logic [9:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge pclk); penable = 1; d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic set_out(input int b, input logic [31:0] v);
    apb_write(10'h100 + 10'(4*b), v);
    for (int i = 0; i < 32; i++) if (b*32 + i < NP) exp_out[b*32 + i] = v[i];
  endtask

  task automatic ctrl(input int dv, input int g, input bit en);
    apb_write(10'h000, (32'(dv) << 16) | (32'(g) << 6) | 32'(en));
  endtask

  task automatic high_len(output int n);
    @(posedge sclk_o); n = 0;
    forever begin @(negedge pclk); if (!sclk_o) break; n++; end
  endtask

  // output chain model
  initial forever begin
    @(posedge sclk_o); rise_cnt++;
    if (ocnt < NP) cap[ocnt] = sdout_o;
    ocnt++;
  end
  // input chain model
  initial forever begin
    @(negedge sclk_o); icnt++;
    sdin_i = (icnt < NP) ? in_pat[icnt] : 1'b0;
  end
  initial forever begin
    @(chain_rst_ev); ocnt = 0; cap = '0; icnt = 0; sdin_i = in_pat[0];
  end
  // scoreboard monitor
  initial forever begin
    @(posedge latch_o); #1;
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front() & nmask(cur_n);
      chk(cap == mon_e, "R4 frame data", cap, mon_e);
      chk(ocnt == cur_n, "R4 rising edges per frame", ocnt, cur_n);
      chk(load_o && !sclk_o, "R6 strobes with clock low", {load_o, sclk_o}, 2'b10);
    end
    ocnt = 0; cap = '0; icnt = 0; sdin_i = in_pat[0];
  end

  initial begin
    repeat (150000) @(posedge pclk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0, n;
    logic [NP-1:0] p1, p2;
    repeat (3) @(negedge pclk);
    presetn = 1'b1;
    @(negedge pclk);
    chk({sclk_o, sdout_o, latch_o, load_o} == 4'b0, "R1 outputs low", {sclk_o, sdout_o, latch_o, load_o}, 0);
    apb_read(10'h000, rd); chk(rd == 0, "R1 control", rd, 0);
    apb_read(10'h200, rd); chk(rd == 0, "R1 readback", rd, 0);
    apb_read(10'h308, rd); chk(rd == 0, "R1 input", rd, 0);

    apb_write(10'h000, 32'hABCD_FFFE);
    apb_read(10'h000, rd); chk(rd == 32'hABCD_03C0, "R2 control fields", rd, 32'hABCD_03C0);
    r0 = rise_cnt; repeat (50) @(negedge pclk);
    chk(rise_cnt == r0 && !latch_o, "R10 disabled quiet", rise_cnt - r0, 0);

    set_out(0, 32'h1234_5678); set_out(1, 32'h9ABC_DEF0); set_out(2, 32'hFFFF_A5C3);
    apb_write(10'h10C, 32'hFFFF_FFFF);
    apb_read(10'h200, rd); chk(rd == 32'h1234_5678, "R8 readback bank0", rd, 32'h1234_5678);
    apb_read(10'h204, rd); chk(rd == 32'h9ABC_DEF0, "R8 readback bank1", rd, 32'h9ABC_DEF0);
    apb_read(10'h208, rd); chk(rd == 32'h0000_A5C3, "R9 top bank masked", rd, 32'h0000_A5C3);
    apb_read(10'h20C, rd); chk(rd == 0, "R9 missing bank", rd, 0);
    apb_read(10'h100, rd); chk(rd == 0, "R8 data offset reads zero", rd, 0);

    ctrl(0, 15, 1); r0 = rise_cnt; repeat (60) @(negedge pclk);
    chk(rise_cnt == r0, "R11 count above limit", rise_cnt - r0, 0);
    ctrl(0, 0, 1); r0 = rise_cnt; repeat (60) @(negedge pclk);
    chk(rise_cnt == r0, "R11 count zero", rise_cnt - r0, 0);

    -> chain_rst_ev; cur_n = 80;
    ctrl(1, 10, 1);
    @(posedge latch_o); #2; exp_q.push_back(exp_out);
    @(posedge latch_o); #3;
    set_out(0, 32'hFFFF_FFFF); set_out(1, 32'h0); set_out(2, 32'h0000_5A5A);
    @(posedge latch_o); #2; exp_q.push_back(exp_out);
    @(posedge latch_o); #3;

    // R12 mid-frame write
    @(posedge latch_o); #2;
    repeat (5) @(posedge sclk_o);
    exp_q.push_back(exp_out);
    set_out(0, 32'h0F0F_00FF);
    @(posedge latch_o); #2; exp_q.push_back(exp_out);
    @(posedge latch_o); #3;
    chk(exp_q.size() == 0, "R12 frames compared", exp_q.size(), 0);

    high_len(n); chk(n == 2, "R3 high phase D=1", n, 2);
    ctrl(3, 10, 1);
    @(posedge latch_o);
    n = 0; forever begin @(negedge pclk); if (!latch_o) break; n++; end
    chk(n == 4, "R6 strobe width D=3", n, 4);
    high_len(n); chk(n == 4, "R3 high phase D=3", n, 4);
    ctrl(0, 10, 1);
    @(posedge latch_o);
    high_len(n); chk(n == 1, "R3 high phase D=0", n, 1);

    p1 = {16'hC3A5, 32'h8000_0001, 32'hDEAD_BEEF};
    p1[70] = 1'b1;
    @(posedge latch_o); #2; in_pat = p1;
    @(posedge latch_o); @(posedge latch_o); #3;
    for (int b = 0; b < NB; b++) begin
      apb_read(10'h300 + 10'(4*b), rd);
      chk(rd == in_bank(p1, b, 80), "R5 input bank", rd, in_bank(p1, b, 80));
    end
    p2 = {16'h1234, 32'h0F0F_F0F0, 32'h5555_AAAA};
    @(posedge latch_o); #2; in_pat = p2;
    repeat (10) @(posedge sclk_o);
    apb_read(10'h300, rd); chk(rd == in_bank(p1, 0, 80), "R7 mid-frame read", rd, in_bank(p1, 0, 80));
    @(posedge latch_o); @(posedge latch_o); #3;
    apb_read(10'h308, rd); chk(rd == in_bank(p2, 2, 80), "R9 input bank2", rd, in_bank(p2, 2, 80));

    ctrl(1, 2, 1); cur_n = 16;
    @(posedge latch_o); #2; exp_q.push_back(exp_out);
    @(posedge latch_o); #3;
    @(posedge latch_o); #3;
    apb_read(10'h300, rd); chk(rd == in_bank(p2, 0, 16), "R9 short frame inputs", rd, in_bank(p2, 0, 16));
    apb_read(10'h304, rd); chk(rd == 0, "R9 pins above count", rd, 0);

    @(posedge latch_o); #2;
    repeat (3) @(posedge sclk_o);
    ctrl(1, 2, 0);
    @(negedge pclk);
    chk(!sclk_o && !latch_o && !load_o, "R10 abort clock low", {sclk_o, latch_o, load_o}, 0);
    r0 = rise_cnt; repeat (50) @(negedge pclk);
    chk(rise_cnt == r0 && !latch_o, "R10 stays stopped", rise_cnt - r0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule